// File: doc/BRIEF.md
# Memory Bus Cycle Sequencer

This block turns a single request from an internal master into one external memory bus cycle. Three cycle kinds are supported: read, write and refresh. Every cycle passes through four base phases (T1, T2, T3, T4), each one bus clock long. Wait states can stretch the cycle at any of the three phase boundaries. The wait count for each boundary comes from a side input, usually driven by a chip-select decoder. The external active-low wait pin can add further waits. Only one cycle is in flight at a time.

The master holds `req_i` with the cycle kind, address and write data until `accept_o` is seen. A request is taken either when the sequencer is idle or during T4 of the cycle in progress. In the T4 case the next cycle, refresh included, follows with no idle clock between the two. The read strobe, write strobe and refresh strobe are active low. Each goes low from the end of T1 to the end of T4 for its own kind of cycle. `done_o` marks T4, and read data is registered on the clock edge that ends T4.

Top module: `mem_cycle_seq`

## Requirements
- R1: After reset, and while idle with no request, `mrd_no`, `mwr_no` and `rfsh_no` are 1, and `done_o` and `data_oe_o` are 0.
- R2: `accept_o` is 1 in a cycle where `req_i` is 1 and the sequencer is idle or in T4. The clock edge that follows starts T1 of the new cycle. All strobes are still inactive during T1.
- R3: With no waits, a cycle lasts exactly 4 clocks, T1 to T4. `done_o` is 1 in the last of these clocks only.
- R4: In a read cycle (`req_kind_i`=0), `mrd_no` is 0 from the clock after T1 through T4, and 1 otherwise. `mwr_no` and `rfsh_no` stay 1.
- R5: In a write cycle (`req_kind_i`=1), `mwr_no` is 0 over the same window. `data_oe_o` is 1 from T1 through T4, and `wdata_o` carries the accepted write data.
- R6: In a refresh cycle (`req_kind_i`=2 or 3), `rfsh_no` is 0 over the same window, `mrd_no` and `mwr_no` stay 1, and `addr_o` is 0.
- R7: The programmed wait counts are latched at accept: `wait_t1_i` is 3 bits, and `wait_t2_i` and `wait_t3_i` are 2 bits each. Each count adds exactly that many clocks at its own boundary: T1/T2, T2/T3 or T3/T4.
- R8: `wait_ni` is sampled at the end of each boundary phase and at the end of each wait clock. Suppose it is held low for K clocks, starting in the phase Tk that precedes a boundary. The waits at that boundary then number max(programmed count, K).
- R9: `rdata_o` takes the `rdata_i` value present in the T4 clock of a read. It holds that value until the next read completes and is not changed by writes or refreshes.
- R10: A request accepted in T4 starts T1 on the very next clock. This holds for any kind, including a refresh following a read.
- R11: For read and write cycles, `addr_o` equals the accepted address and is stable from T1 through T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request for a bus cycle |
| req_kind_i | input | 2 | 0 read, 1 write, 2 or 3 refresh |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Write data |
| wait_t1_i | input | 3 | Programmed waits at T1/T2 |
| wait_t2_i | input | 2 | Programmed waits at T2/T3 |
| wait_t3_i | input | 2 | Programmed waits at T3/T4 |
| wait_ni | input | 1 | External wait, active low |
| rdata_i | input | DATA_W | Read data from the bus |
| accept_o | output | 1 | Request taken this clock |
| done_o | output | 1 | Cycle is in T4 |
| addr_o | output | ADDR_W | Bus address |
| wdata_o | output | DATA_W | Bus write data |
| data_oe_o | output | 1 | Write data drive enable |
| rdata_o | output | DATA_W | Registered read data |
| mrd_no | output | 1 | Read strobe, active low |
| mwr_no | output | 1 | Write strobe, active low |
| rfsh_no | output | 1 | Refresh strobe, active low |

## Verification
The bench varies the wait count separately at each boundary, using the 3-bit maximum at T1/T2. A counter that dropped a wait, or charged it to the wrong boundary, would produce the wrong cycle length. A boundary that ignored the counts latched at accept would do the same. External wait windows are placed both shorter and longer than the programmed count. This catches a design that adds the two counts instead of taking the larger, and one that samples the pin inside the programmed waits. A read is followed directly by a refresh requested during T4, which exposes an idle bubble or a dropped request. Read data is changed on the clock before T4, so a capture made one edge early is caught, as is one that writes or refreshes overwrite.

// File: rtl/mem_cycle_pkg.sv
package mem_cycle_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_T1, PH_W1, PH_T2, PH_W2, PH_T3, PH_W3, PH_T4
  } phase_e;

  typedef enum logic [1:0] {
    KIND_RD = 2'd0, KIND_WR = 2'd1, KIND_RF = 2'd2, KIND_RF2 = 2'd3
  } kind_e;

  function automatic logic is_refresh(kind_e k);
    return k[1];
  endfunction
endpackage

// File: rtl/mem_cycle_fsm.sv
module mem_cycle_fsm
  import mem_cycle_pkg::*;
#(
  parameter int W1_W = 3,
  parameter int W23_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [W1_W-1:0]  wait_t1_i,
  input  logic [W23_W-1:0] wait_t2_i,
  input  logic [W23_W-1:0] wait_t3_i,
  input  logic             wait_ni,
  output logic             accept_o,
  output phase_e           phase_o
);
  localparam int CNT_W = (W1_W > W23_W) ? W1_W : W23_W;

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W23_W-1:0] w2_q, w3_q;

  assign accept_o = req_i && (ph_q == PH_IDLE || ph_q == PH_T4);
  assign phase_o  = ph_q;

  // Leaving a base phase: load programmed waits, or take one wait if pin low.
  function automatic void leave_base(input logic [CNT_W-1:0] prog, input phase_e wph,
                                     input phase_e nph, input logic ext_n,
                                     output phase_e ph, output logic [CNT_W-1:0] cnt);
    if (prog != '0) begin
      ph = wph; cnt = prog - 1'b1;
    end else if (!ext_n) begin
      ph = wph; cnt = '0;
    end else begin
      ph = nph; cnt = '0;
    end
  endfunction

  function automatic void in_wait(input logic [CNT_W-1:0] c, input phase_e wph,
                                  input phase_e nph, input logic ext_n,
                                  output phase_e ph, output logic [CNT_W-1:0] cnt);
    if (c != '0) begin
      ph = wph; cnt = c - 1'b1;
    end else if (!ext_n) begin
      ph = wph; cnt = '0;
    end else begin
      ph = nph; cnt = '0;
    end
  endfunction

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE: if (req_i) ph_d = PH_T1;
      PH_T1:   leave_base(CNT_W'(wait_t1_q), PH_W1, PH_T2, wait_ni, ph_d, cnt_d);
      PH_W1:   in_wait(cnt_q, PH_W1, PH_T2, wait_ni, ph_d, cnt_d);
      PH_T2:   leave_base(CNT_W'(w2_q), PH_W2, PH_T3, wait_ni, ph_d, cnt_d);
      PH_W2:   in_wait(cnt_q, PH_W2, PH_T3, wait_ni, ph_d, cnt_d);
      PH_T3:   leave_base(CNT_W'(w3_q), PH_W3, PH_T4, wait_ni, ph_d, cnt_d);
      PH_W3:   in_wait(cnt_q, PH_W3, PH_T4, wait_ni, ph_d, cnt_d);
      PH_T4:   ph_d = req_i ? PH_T1 : PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  logic [W1_W-1:0] wait_t1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      wait_t1_q <= '0;
      w2_q      <= '0;
      w3_q      <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      if (accept_o) begin
        wait_t1_q <= wait_t1_i;
        w2_q      <= wait_t2_i;
        w3_q      <= wait_t3_i;
      end
    end
  end

  assert_accept_t1_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> (ph_q == PH_T1));

  assert_wait_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ph_q == PH_W1 || ph_q == PH_W2 || ph_q == PH_W3) && cnt_q != '0) |=> $stable(ph_q));

  assert_ext_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ph_q == PH_W1 || ph_q == PH_W2 || ph_q == PH_W3) && !wait_ni) |=> $stable(ph_q));

  assert_t4_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_T4) |=> (ph_q == PH_T1 || ph_q == PH_IDLE));
endmodule

// File: rtl/mem_cycle_dpath.sv
module mem_cycle_dpath
  import mem_cycle_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  phase_e            phase_i,
  input  logic [1:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] rdata_i,
  output kind_e             kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  kind_e             kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= KIND_RD;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept_i) begin
        kind_q  <= kind_e'(req_kind_i);
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      // capture on the edge that closes T4
      if (phase_i == PH_T4 && kind_q == KIND_RD) rdata_q <= rdata_i;
    end
  end

  assign kind_o  = kind_q;
  assign addr_o  = is_refresh(kind_q) ? '0 : addr_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;

  assert_addr_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i != PH_IDLE && phase_i != PH_T1 && !is_refresh(kind_q)) |-> $stable(addr_o));

  assert_rdata_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_q != KIND_RD) |=> $stable(rdata_o));
endmodule

// File: rtl/mem_cycle_strobe.sv
module mem_cycle_strobe
  import mem_cycle_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_e phase_i,
  input  kind_e  kind_i,
  output logic   mrd_no,
  output logic   mwr_no,
  output logic   rfsh_no,
  output logic   data_oe_o,
  output logic   done_o
);
  logic past_t1;
  logic busy;

  assign busy    = (phase_i != PH_IDLE);
  assign past_t1 = busy && (phase_i != PH_T1);

  assign mrd_no    = !(past_t1 && kind_i == KIND_RD);
  assign mwr_no    = !(past_t1 && kind_i == KIND_WR);
  assign rfsh_no   = !(past_t1 && is_refresh(kind_i));
  assign data_oe_o = busy && kind_i == KIND_WR;
  assign done_o    = (phase_i == PH_T4);

  assert_strobe_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({!mrd_no, !mwr_no, !rfsh_no}));

  assert_strobe_after_t1_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(mrd_no) || $fell(mwr_no) || $fell(rfsh_no)) |-> $past(phase_i == PH_T1));

  assert_done_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(mrd_no && mwr_no && rfsh_no));
endmodule

// File: rtl/mem_cycle_seq.sv
module mem_cycle_seq
  import mem_cycle_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int W1_W   = 3,
  parameter int W23_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [W1_W-1:0]   wait_t1_i,
  input  logic [W23_W-1:0]  wait_t2_i,
  input  logic [W23_W-1:0]  wait_t3_i,
  input  logic              wait_ni,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              accept_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              data_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mrd_no,
  output logic              mwr_no,
  output logic              rfsh_no
);
  phase_e phase;
  kind_e  kind;

  mem_cycle_fsm #(.W1_W(W1_W), .W23_W(W23_W)) u_fsm (
    .clk_i, .rst_ni, .req_i,
    .wait_t1_i, .wait_t2_i, .wait_t3_i, .wait_ni,
    .accept_o, .phase_o(phase)
  );

  mem_cycle_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk_i, .rst_ni, .accept_i(accept_o), .phase_i(phase),
    .req_kind_i, .req_addr_i, .req_wdata_i, .rdata_i,
    .kind_o(kind), .addr_o, .wdata_o, .rdata_o
  );

  mem_cycle_strobe u_strobe (
    .clk_i, .rst_ni, .phase_i(phase), .kind_i(kind),
    .mrd_no, .mwr_no, .rfsh_no, .data_oe_o, .done_o
  );
endmodule

// File: tb/mem_cycle_seq_tb.sv
module mem_cycle_seq_tb_top;
  localparam int AW = 24;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [1:0]    kind = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [2:0]    w1 = '0;
  logic [1:0]    w2 = '0, w3 = '0;
  logic          wait_n = 1'b1;
  logic [DW-1:0] rdata = '0;
  logic          accept, done, data_oe, mrd_n, mwr_n, rfsh_n;
  logic [AW-1:0] addr_out;
  logic [DW-1:0] wdata_out, rdata_out;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  mem_cycle_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_kind_i(kind),
    .req_addr_i(addr), .req_wdata_i(wdata),
    .wait_t1_i(w1), .wait_t2_i(w2), .wait_t3_i(w3), .wait_ni(wait_n),
    .rdata_i(rdata), .accept_o(accept), .done_o(done), .addr_o(addr_out),
    .wdata_o(wdata_out), .data_oe_o(data_oe), .rdata_o(rdata_out),
    .mrd_no(mrd_n), .mwr_no(mwr_n), .rfsh_no(rfsh_n)
  );

  task automatic chk(input bit ok, input string req_tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req_tag, act, exp, $time);
    end
  endtask

  function automatic int maxi(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Runs one cycle. ext_b selects the boundary (1..3, 0 none) whose base
  // phase starts an external wait window of ext_k clocks.
  task automatic run_txn(input logic [1:0] k, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input int p1, input int p2,
                         input int p3, input int ext_b, input int ext_k,
                         input logic [DW-1:0] rd_val, input string tag);
    int ws1, ws2, ws3, len, es;
    logic [DW-1:0] prev_rd;
    int bad0;
    bad0 = bad;
    ws1 = (ext_b == 1) ? maxi(p1, ext_k) : p1;
    ws2 = (ext_b == 2) ? maxi(p2, ext_k) : p2;
    ws3 = (ext_b == 3) ? maxi(p3, ext_k) : p3;
    len = 4 + ws1 + ws2 + ws3;
    es  = (ext_b == 1) ? 0 : (ext_b == 2) ? 1 + ws1 : 2 + ws1 + ws2;
    prev_rd = rdata_out;
    @(negedge clk);
    req = 1'b1; kind = k; addr = a; wdata = d;
    w1 = 3'(p1); w2 = 2'(p2); w3 = 2'(p3);
    #1 chk(accept === 1'b1, {tag, " R2 accept"}, 32'(accept), 1);
    @(negedge clk);
    req = 1'b0; w1 = '0; w2 = '0; w3 = '0;
    for (int idx = 0; idx < len; idx++) begin
      if (idx != 0) @(negedge clk);
      wait_n = !(ext_b != 0 && idx >= es && idx < es + ext_k);
      rdata  = (idx == len - 1) ? rd_val : ~rd_val;
      #1;
      if (idx == 0) begin
        chk({mrd_n, mwr_n, rfsh_n} === 3'b111, {tag, " R2 T1 strobes idle"},
            32'({mrd_n, mwr_n, rfsh_n}), 7);
      end else begin
        chk(mrd_n === !(k == 2'd0), {tag, " R4 mrd window"}, 32'(mrd_n), 32'(!(k == 2'd0)));
        chk(mwr_n === !(k == 2'd1), {tag, " R5 mwr window"}, 32'(mwr_n), 32'(!(k == 2'd1)));
        chk(rfsh_n === !k[1], {tag, " R6 rfsh window"}, 32'(rfsh_n), 32'(!k[1]));
      end
      chk(done === (idx == len - 1), {tag, " R3 R7 R8 done position"}, 32'(done),
          32'(idx == len - 1));
      chk(data_oe === (k == 2'd1), {tag, " R5 data_oe"}, 32'(data_oe), 32'(k == 2'd1));
      if (k == 2'd1)
        chk(wdata_out === d, {tag, " R5 wdata"}, 32'(wdata_out), 32'(d));
      if (k[1])
        chk(addr_out === '0, {tag, " R6 addr zero"}, 32'(addr_out), 0);
      else
        chk(addr_out === a, {tag, " R11 addr held"}, 32'(addr_out), 32'(a));
    end
    wait_n = 1'b1;
    @(negedge clk); #1;
    chk(done === 1'b0 && mrd_n && mwr_n && rfsh_n, {tag, " R1 back to idle"},
        32'({done, mrd_n, mwr_n, rfsh_n}), 32'h7);
    if (k == 2'd0)
      chk(rdata_out === rd_val, {tag, " R9 rdata captured"}, 32'(rdata_out), 32'(rd_val));
    else
      chk(rdata_out === prev_rd, {tag, " R9 rdata kept"}, 32'(rdata_out), 32'(prev_rd));
    if (bad != bad0) $display("  in scenario %s len=%0d", tag, len);
  endtask

  task automatic t_reset();
    #1;
    chk({mrd_n, mwr_n, rfsh_n} === 3'b111, "R1 reset strobes", 32'({mrd_n, mwr_n, rfsh_n}), 7);
    chk(done === 1'b0 && data_oe === 1'b0, "R1 reset done/oe", 32'({done, data_oe}), 0);
    chk(accept === 1'b0, "R2 no accept idle", 32'(accept), 0);
  endtask

  task automatic t_base();
    run_txn(2'd0, 24'h12_3456, '0, 0, 0, 0, 0, 0, 16'hA5C3, "read_nowait R3");
    run_txn(2'd1, 24'h00_F00D, 16'hBEEF, 0, 0, 0, 0, 0, 16'h1111, "write_nowait R5");
    run_txn(2'd2, 24'hFF_FFFF, '0, 0, 0, 0, 0, 0, 16'h2222, "refresh R6");
    run_txn(2'd3, 24'h55_5555, '0, 0, 0, 0, 0, 0, 16'h3333, "refresh_k3 R6");
  endtask

  task automatic t_prog_waits();
    run_txn(2'd0, 24'h00_0100, '0, 7, 0, 0, 0, 0, 16'h0707, "w1max R7");
    run_txn(2'd1, 24'h00_0200, 16'h4242, 0, 3, 0, 0, 0, 16'h0, "w2 R7");
    run_txn(2'd0, 24'h00_0300, '0, 0, 0, 2, 0, 0, 16'h0303, "w3 R7");
    run_txn(2'd2, 24'h00_0400, '0, 1, 1, 1, 0, 0, 16'h0, "wall_refresh R7");
  endtask

  task automatic t_ext_waits();
    run_txn(2'd0, 24'h00_1000, '0, 0, 0, 0, 1, 3, 16'h1001, "ext_t1 R8");
    run_txn(2'd0, 24'h00_2000, '0, 2, 0, 0, 1, 5, 16'h2002, "ext_gt_prog R8");
    run_txn(2'd1, 24'h00_3000, 16'h3003, 3, 0, 0, 1, 1, 16'h0, "ext_lt_prog R8");
    run_txn(2'd0, 24'h00_4000, '0, 1, 0, 0, 2, 2, 16'h4004, "ext_t2 R8");
    run_txn(2'd0, 24'h00_5000, '0, 0, 1, 1, 3, 4, 16'h5005, "ext_t3 R8");
  endtask

  task automatic t_back_to_back();
    int len;
    @(negedge clk);
    req = 1'b1; kind = 2'd0; addr = 24'h0A_0A0A; w1 = 3'd1;
    @(negedge clk);
    req = 1'b0; w1 = '0;
    len = 5;
    for (int idx = 1; idx < len; idx++) begin
      @(negedge clk);
      rdata = (idx == len - 1) ? 16'h9C9C : 16'h0000;
      if (idx == len - 1) begin
        req = 1'b1; kind = 2'd2;
        #1 chk(accept === 1'b1 && done === 1'b1, "R10 accept in T4",
               32'({accept, done}), 3);
      end
    end
    @(negedge clk);
    req = 1'b0; #1;
    chk({mrd_n, mwr_n, rfsh_n, done} === 4'b1110, "R10 T1 follows T4",
        32'({mrd_n, mwr_n, rfsh_n, done}), 32'hE);
    chk(rdata_out === 16'h9C9C, "R9 R10 rdata from chained read", 32'(rdata_out), 32'h9C9C);
    for (int idx = 1; idx < 4; idx++) begin
      @(negedge clk); #1;
      chk(rfsh_n === 1'b0 && mrd_n === 1'b1, "R10 R6 chained refresh strobe",
          32'({rfsh_n, mrd_n}), 1);
      chk(done === (idx == 3), "R10 R3 chained done", 32'(done), 32'(idx == 3));
    end
    @(negedge clk); #1;
    chk(done === 1'b0 && rfsh_n === 1'b1, "R1 idle after chain", 32'({done, rfsh_n}), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_base();
    t_prog_waits();
    t_ext_waits();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule